// File: doc/BRIEF.md
# Interrupt Entry Flag Sequencer

This block performs the processor-side work that follows the acceptance of an interrupt request. The arbiter hands it a request class, a software vector number and a request priority. The block picks a stack from the current stack select flag and the request kind. It saves the program counter and the flag register onto that stack as three word writes through a simple write port with a ready handshake. It then returns the updated stack pointer to the core and rewrites the stack select, interrupt enable, debug and priority level fields of the flag register.

The block holds the flag register itself. Outside an entry sequence the core can load the flag register through a load port. Stack pointer values come in as inputs. The block samples them when it accepts a request and writes the result back for one cycle. A one-cycle done pulse marks the end of every sequence.

A reset request writes nothing to memory. It clears the whole flag register and then signals done.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is taken only while `req_ready` is high. `req_ready` is high only while the block is idle. While a sequence is running, `req_valid` has no effect. Class codes on `req_class` are: 0 reset, 1 NMI, 2 watchdog, 3 debug, 4 single-step, 5 address-match, 6 software interrupt, 7 maskable.
- R2: Every non-reset request, except a software interrupt with vector 32 to 63, pushes onto the interrupt stack (`isp_in`). At the end it writes back `isp_in - 6` with `sp_wb_user` low.
- R3: A software interrupt with vector 32 to 63 uses the stack picked by flag bit 7 at acceptance time: 1 selects `usp_in`, 0 selects `isp_in`. The block writes back that pointer minus 6, with `sp_wb_user` equal to that bit. Bit 7 keeps its value.
- R4: The three writes, in order, are:
  - address SP-2, data {flag[15:8], 4'b0000, pc[19:16]};
  - address SP-4, data pc[15:0];
  - address SP-6, data {8'h00, flag[7:0]}.
  The flag value pushed is the one in force before the interrupt.
- R5: While `mem_wr_valid` is high and `mem_ready` is low, the write stays asserted and its address and data do not change.
- R6: After a non-reset entry, the interrupt enable bit (bit 6) and the debug bit (bit 2) are 0. The stack select bit (bit 7) is 0, except in the R3 case. All bits outside 14:12, 7, 6 and 2 are unchanged.
- R7: The priority level field (bits 14:12) becomes:
  - `req_level` for a maskable request;
  - 3'b111 for NMI or watchdog;
  - unchanged for debug, single-step, address-match and software interrupt requests.
- R8: A reset request makes no memory write and no stack pointer write-back. It leaves the flag register at 16'h0000.
- R9: `done` is a one-cycle pulse. The updated flag value is visible on `flag` while `done` is high. `sp_wb_valid` is high for exactly the one cycle before `done`.
- R10: `flag_ld` loads `flag_ld_data` into the flag register on the next edge only while the block is idle and no request is being taken. While a sequence is running, the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Accepted interrupt request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_class | input | 3 | Request class code |
| req_vector | input | 6 | Software vector number |
| req_level | input | 3 | Priority level of the request |
| pc_in | input | 20 | Program counter to save |
| isp_in | input | 16 | Interrupt stack pointer |
| usp_in | input | 16 | User stack pointer |
| flag_ld | input | 1 | Core load of the flag register |
| flag_ld_data | input | 16 | Value for the flag load |
| flag | output | 16 | Current flag register |
| mem_wr_valid | output | 1 | Stack write request |
| mem_addr | output | 16 | Stack write byte address |
| mem_wdata | output | 16 | Stack write data word |
| mem_ready | input | 1 | Write accepted this cycle |
| sp_wb_valid | output | 1 | Stack pointer write-back strobe |
| sp_wb_user | output | 1 | Write-back targets user stack pointer |
| sp_wb_data | output | 16 | New stack pointer value |
| done | output | 1 | Entry sequence finished |

## Verification
The bench goes after software vectors 31, 32 and 63 with the stack select bit both set and clear. If the range test were off, a design would push to the wrong stack, or would clear bit 7 where it must keep it. It drives long write stalls and flag loads in the middle of a sequence. A design that advanced on a stalled write would skip or duplicate a word. A design that honoured a busy load would push or update from a corrupted flag. Each class is checked for its own priority level rule, so swapping the forced-7 and keep cases shows up. Reset requests are checked for zero writes and no write-back.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    CLS_RESET = 3'd0,
    CLS_NMI   = 3'd1,
    CLS_WDOG  = 3'd2,
    CLS_DEBUG = 3'd3,
    CLS_STEP  = 3'd4,
    CLS_AMATCH= 3'd5,
    CLS_SOFT  = 3'd6,
    CLS_MASK  = 3'd7
  } irq_class_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH1  = 3'd1,
    ST_PUSH2  = 3'd2,
    ST_PUSH3  = 3'd3,
    ST_UPDATE = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_e;

  localparam int FLAG_W   = 16;
  localparam int LVL_W    = 3;
  localparam int LVL_LSB  = 12;
  localparam int SEL_BIT  = 7;
  localparam int IEN_BIT  = 6;
  localparam int DBG_BIT  = 2;
  localparam int PUSH_CNT = 3;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_is_reset,
  input  logic       mem_ready,
  output seq_state_e state,
  output logic       accept,
  output logic       pushing,
  output logic       upd,
  output logic       done
);

  seq_state_e state_d;

  assign accept  = (state == ST_IDLE) && req_valid;
  assign pushing = (state == ST_PUSH1) || (state == ST_PUSH2) || (state == ST_PUSH3);
  assign upd     = (state == ST_UPDATE);
  assign done    = (state == ST_DONE);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (req_valid) state_d = req_is_reset ? ST_UPDATE : ST_PUSH1;
      ST_PUSH1:  if (mem_ready) state_d = ST_PUSH2;
      ST_PUSH2:  if (mem_ready) state_d = ST_PUSH3;
      ST_PUSH3:  if (mem_ready) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // R1: a taken request always leaves idle on the next edge
  a_r1_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state != ST_IDLE));

  // R9: done lasts one cycle and is preceded by the update cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_update_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> done);

endmodule

// File: rtl/irq_entry_flags.sv
module irq_entry_flags
  import irq_entry_pkg::*;
#(
  parameter int VEC_W       = 6,
  parameter int SW_KEEP_MIN = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              upd,
  input  logic              idle,
  input  logic [2:0]        req_class,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              ld_en,
  input  logic [FLAG_W-1:0] ld_data,
  output logic [FLAG_W-1:0] flag,
  output logic              stack_sel_now,
  output logic              stack_sel_q,
  output logic              cls_reset_q
);

  localparam logic [VEC_W-1:0] KEEP_MIN = VEC_W'(SW_KEEP_MIN);

  irq_class_e         cls_q;
  logic [LVL_W-1:0]   lvl_q;
  logic               keep_sel_now;
  logic [FLAG_W-1:0]  flag_d;
  logic [FLAG_W-1:0]  flag_next_entry;
  logic               flag_en;
  logic               ld_ok;

  assign keep_sel_now  = (irq_class_e'(req_class) == CLS_SOFT) && (req_vector >= KEEP_MIN);
  assign stack_sel_now = keep_sel_now ? flag[SEL_BIT] : 1'b0;
  assign cls_reset_q   = (cls_q == CLS_RESET);
  assign ld_ok         = idle && ld_en && !accept;

  // request capture register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q       <= CLS_RESET;
      lvl_q       <= '0;
      stack_sel_q <= 1'b0;
    end else if (accept) begin
      cls_q       <= irq_class_e'(req_class);
      lvl_q       <= req_level;
      stack_sel_q <= stack_sel_now;
    end
  end

  // new flag value for the captured request
  always_comb begin
    flag_next_entry = flag;
    flag_next_entry[IEN_BIT] = 1'b0;
    flag_next_entry[DBG_BIT] = 1'b0;
    flag_next_entry[SEL_BIT] = stack_sel_q;
    unique case (cls_q)
      CLS_RESET: flag_next_entry = '0;
      CLS_NMI,
      CLS_WDOG:  flag_next_entry[LVL_LSB +: LVL_W] = '1;
      CLS_MASK:  flag_next_entry[LVL_LSB +: LVL_W] = lvl_q;
      default:   flag_next_entry[LVL_LSB +: LVL_W] = flag[LVL_LSB +: LVL_W];
    endcase
  end

  always_comb begin
    flag_en = 1'b0;
    flag_d  = flag;
    if (upd) begin
      flag_en = 1'b1;
      flag_d  = flag_next_entry;
    end else if (ld_ok) begin
      flag_en = 1'b1;
      flag_d  = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= '0;
    else if (flag_en) flag <= flag_d;
  end

  // R10: the flag only moves after an update cycle or an idle load
  a_r10_flag_change_src: assert property (@(posedge clk) disable iff (!rst_n)
    (flag != $past(flag)) |-> ($past(upd) || ($past(idle) && $past(ld_en))));

  // R8: a reset request leaves the flag cleared
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cls_reset_q) |=> (flag == '0));

  // R7: NMI and watchdog force the top level
  a_r7_forced_top: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ((cls_q == CLS_NMI) || (cls_q == CLS_WDOG))) |=> (flag[LVL_LSB +: LVL_W] == '1));

  // R6: enable and debug are clear after any non-reset entry
  a_r6_ien_dbg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cls_reset_q) |=> (!flag[IEN_BIT] && !flag[DBG_BIT]));

endmodule

// File: rtl/irq_entry_push.sv
module irq_entry_push
  import irq_entry_pkg::*;
#(
  parameter int AW     = 16,
  parameter int PC_W   = 20,
  parameter int WORD_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  seq_state_e        state,
  input  logic              upd,
  input  logic              no_push,
  input  logic              stack_sel_now,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [AW-1:0]     isp_in,
  input  logic [AW-1:0]     usp_in,
  input  logic [FLAG_W-1:0] flag,
  input  logic              mem_ready,
  output logic              mem_wr_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              sp_wb_valid,
  output logic [AW-1:0]     sp_wb_data
);

  localparam int BYTES    = WORD_W / 8;
  localparam int HALF_W   = WORD_W / 2;
  localparam int PC_HI_W  = PC_W - WORD_W;
  localparam int PAD_W    = HALF_W - PC_HI_W;
  localparam logic [AW-1:0] STEP  = AW'(BYTES);
  localparam logic [AW-1:0] TOTAL = AW'(BYTES * PUSH_CNT);

  logic [AW-1:0]     base_q;
  logic [PC_W-1:0]   pc_q;
  logic [FLAG_W-1:0] flag_snap_q;
  logic [AW-1:0]     addr_sel;
  logic [WORD_W-1:0] data_sel;

  // snapshot of the values to save, taken when the request is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      pc_q        <= '0;
      flag_snap_q <= '0;
    end else if (accept) begin
      base_q      <= stack_sel_now ? usp_in : isp_in;
      pc_q        <= pc_in;
      flag_snap_q <= flag;
    end
  end

  always_comb begin
    addr_sel = base_q;
    data_sel = '0;
    unique case (state)
      ST_PUSH1: begin
        addr_sel = base_q - STEP;
        data_sel = {flag_snap_q[FLAG_W-1 -: HALF_W], {PAD_W{1'b0}}, pc_q[PC_W-1:WORD_W]};
      end
      ST_PUSH2: begin
        addr_sel = base_q - (STEP + STEP);
        data_sel = pc_q[WORD_W-1:0];
      end
      ST_PUSH3: begin
        addr_sel = base_q - TOTAL;
        data_sel = {{HALF_W{1'b0}}, flag_snap_q[HALF_W-1:0]};
      end
      default: begin
        addr_sel = base_q;
        data_sel = '0;
      end
    endcase
  end

  assign mem_wr_valid = (state == ST_PUSH1) || (state == ST_PUSH2) || (state == ST_PUSH3);
  assign mem_addr     = addr_sel;
  assign mem_wdata    = data_sel;
  assign sp_wb_valid  = upd && !no_push;
  assign sp_wb_data   = base_q - TOTAL;

  // R5: a stalled write holds still
  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_ready) |=> (mem_wr_valid && $stable(mem_addr) && $stable(mem_wdata)));

  // R4: each completed write moves the address down by one word
  a_r4_addr_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_ready && (state != ST_PUSH3)) |=> (mem_addr == $past(mem_addr) - STEP));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW          = 16,
  parameter int PC_W        = 20,
  parameter int VEC_W       = 6,
  parameter int SW_KEEP_MIN = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_class,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic [2:0]        req_level,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [AW-1:0]     isp_in,
  input  logic [AW-1:0]     usp_in,
  input  logic              flag_ld,
  input  logic [15:0]       flag_ld_data,
  output logic [15:0]       flag,
  output logic              mem_wr_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ready,
  output logic              sp_wb_valid,
  output logic              sp_wb_user,
  output logic [AW-1:0]     sp_wb_data,
  output logic              done
);

  seq_state_e state;
  logic accept, pushing, upd;
  logic stack_sel_now, stack_sel_q, cls_reset_q;

  irq_entry_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_reset (irq_class_e'(req_class) == CLS_RESET),
    .mem_ready    (mem_ready),
    .state        (state),
    .accept       (accept),
    .pushing      (pushing),
    .upd          (upd),
    .done         (done)
  );

  irq_entry_flags #(.VEC_W(VEC_W), .SW_KEEP_MIN(SW_KEEP_MIN)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .upd           (upd),
    .idle          (state == ST_IDLE),
    .req_class     (req_class),
    .req_vector    (req_vector),
    .req_level     (req_level),
    .ld_en         (flag_ld),
    .ld_data       (flag_ld_data),
    .flag          (flag),
    .stack_sel_now (stack_sel_now),
    .stack_sel_q   (stack_sel_q),
    .cls_reset_q   (cls_reset_q)
  );

  irq_entry_push #(.AW(AW), .PC_W(PC_W), .WORD_W(16)) u_push (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .state         (state),
    .upd           (upd),
    .no_push       (cls_reset_q),
    .stack_sel_now (stack_sel_now),
    .pc_in         (pc_in),
    .isp_in        (isp_in),
    .usp_in        (usp_in),
    .flag          (flag),
    .mem_ready     (mem_ready),
    .mem_wr_valid  (mem_wr_valid),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .sp_wb_valid   (sp_wb_valid),
    .sp_wb_data    (sp_wb_data)
  );

  assign req_ready  = (state == ST_IDLE);
  assign sp_wb_user = stack_sel_q;

  // R1: ready and an active write never coincide
  a_r1_ready_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_wr_valid && !done && !sp_wb_valid));

  // R8: a reset request never drives the write port
  a_r8_no_write_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_class == 3'd0)) |=> !mem_wr_valid);

  // R9: write-back is one cycle ahead of done
  a_r9_wb_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wb_valid |=> done);

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [2:0]  req_class, req_level;
  logic [5:0]  req_vector;
  logic [19:0] pc_in;
  logic [15:0] isp_in, usp_in;
  logic        flag_ld;
  logic [15:0] flag_ld_data, flag;
  logic        mem_wr_valid, mem_ready;
  logic [15:0] mem_addr, mem_wdata;
  logic        sp_wb_valid, sp_wb_user;
  logic [15:0] sp_wb_data;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [15:0] model_flag;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_vector(req_vector), .req_level(req_level),
    .pc_in(pc_in), .isp_in(isp_in), .usp_in(usp_in),
    .flag_ld(flag_ld), .flag_ld_data(flag_ld_data), .flag(flag),
    .mem_wr_valid(mem_wr_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .sp_wb_valid(sp_wb_valid), .sp_wb_user(sp_wb_user),
    .sp_wb_data(sp_wb_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flag(logic [15:0] f, logic [2:0] cls, logic [5:0] vec, logic [2:0] lvl);
    logic [15:0] r;
    if (cls == 3'd0) return 16'h0000;
    r = f;
    r[6] = 1'b0;
    r[2] = 1'b0;
    if (!(cls == 3'd6 && vec >= 6'd32)) r[7] = 1'b0;
    if (cls == 3'd1 || cls == 3'd2) r[14:12] = 3'b111;
    else if (cls == 3'd7)           r[14:12] = lvl;
    return r;
  endfunction

  task automatic load_flag(input logic [15:0] v);
    @(negedge clk);
    flag_ld = 1'b1; flag_ld_data = v;
    @(negedge clk);
    flag_ld = 1'b0;
    check(flag == v, "R10 idle load", {16'h0, flag}, {16'h0, v});
    model_flag = v;
  endtask

  task automatic run_req(input logic [2:0] cls, input logic [5:0] vec, input logic [2:0] lvl,
                         input logic [19:0] pc, input logic [15:0] isp, input logic [15:0] usp,
                         input bit noise);
    logic [15:0] exp_addr [3];
    logic [15:0] exp_data [3];
    logic [15:0] base, eflag;
    bit user, saw_wb, finished;
    int k, nexp;
    user  = (cls == 3'd6 && vec >= 6'd32) ? model_flag[7] : 1'b0;
    base  = user ? usp : isp;
    eflag = exp_flag(model_flag, cls, vec, lvl);
    nexp  = (cls == 3'd0) ? 0 : 3;
    exp_addr[0] = base - 16'd2; exp_data[0] = {model_flag[15:8], 4'b0000, pc[19:16]};
    exp_addr[1] = base - 16'd4; exp_data[1] = pc[15:0];
    exp_addr[2] = base - 16'd6; exp_data[2] = {8'h00, model_flag[7:0]};
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready when idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_class = cls; req_vector = vec; req_level = lvl;
    pc_in = pc; isp_in = isp; usp_in = usp;
    @(negedge clk);
    req_valid = 1'b0;
    isp_in = ~isp; usp_in = ~usp; pc_in = ~pc;
    k = 0; saw_wb = 0; finished = 0;
    for (int c = 0; c < 300 && !finished; c++) begin
      if (mem_wr_valid) begin
        if (k < 3) begin
          check(mem_addr == exp_addr[k], "R4/R5 write address", {16'h0, mem_addr}, {16'h0, exp_addr[k]});
          check(mem_wdata == exp_data[k], "R4/R5 write data", {16'h0, mem_wdata}, {16'h0, exp_data[k]});
        end else begin
          check(1'b0, "R8 unexpected write", k, nexp);
        end
      end
      if (sp_wb_valid) begin
        saw_wb = 1;
        check(sp_wb_data == base - 16'd6, "R2/R3 sp write-back value", {16'h0, sp_wb_data}, {16'h0, base - 16'd6});
        check(sp_wb_user == user, "R2/R3 sp write-back select", {31'h0, sp_wb_user}, {31'h0, user});
      end
      if (done) begin
        finished = 1;
        check(flag == eflag, "R6/R7/R8 flag after entry", {16'h0, flag}, {16'h0, eflag});
        check(k == nexp, "R8 write count", k, nexp);
        check(saw_wb == (cls != 3'd0), "R9/R8 write-back seen", {31'h0, saw_wb}, {31'h0, cls != 3'd0});
        req_valid = 1'b0; flag_ld = 1'b0; mem_ready = 1'b0;
      end else begin
        check(req_ready == 1'b0, "R1 not ready while busy", {31'h0, req_ready}, 32'h0);
        flag_ld = noise && (k == 1);
        flag_ld_data = ~model_flag;
        req_valid = noise;
        req_class = 3'd0;
        mem_ready = ($urandom % 3) != 0;
        if (mem_wr_valid && mem_ready) k++;
      end
      @(negedge clk);
    end
    check(finished == 1, "R9 done reached", {31'h0, finished}, 32'h1);
    check(done == 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
    check(flag == eflag, "R10 flag stable after done", {16'h0, flag}, {16'h0, eflag});
    model_flag = eflag;
  endtask

  initial begin
    @(posedge clk);
    while (cycles < WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_class = '0; req_vector = '0; req_level = '0;
    pc_in = '0; isp_in = '0; usp_in = '0; flag_ld = 1'b0; flag_ld_data = '0; mem_ready = 1'b0;
    model_flag = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flag == 16'h0, "R8 reset flag", {16'h0, flag}, 32'h0);
    check(req_ready == 1'b1 && !mem_wr_valid && !done && !sp_wb_valid, "R1 reset outputs",
          {28'h0, req_ready, mem_wr_valid, done, sp_wb_valid}, 32'h8);

    load_flag(16'h3FC4);
    run_req(3'd1, 6'd0, 3'd2, 20'hABCDE, 16'h8000, 16'h4000, 0);
    load_flag(16'h20C4);
    run_req(3'd2, 6'd0, 3'd0, 20'h12345, 16'h7F00, 16'h3000, 1);
    load_flag(16'h50C4);
    run_req(3'd7, 6'd0, 3'd5, 20'hF0F0F, 16'h9000, 16'h5000, 0);
    load_flag(16'h40C4);
    run_req(3'd6, 6'd40, 3'd0, 20'h55555, 16'h9000, 16'h5000, 0);
    load_flag(16'h40C4);
    run_req(3'd6, 6'd31, 3'd0, 20'h55555, 16'h9000, 16'h5000, 0);
    load_flag(16'h6084);
    run_req(3'd6, 6'd32, 3'd0, 20'h11111, 16'h9000, 16'h5000, 1);
    load_flag(16'h6004);
    run_req(3'd6, 6'd63, 3'd0, 20'h22222, 16'h9000, 16'h5000, 0);
    load_flag(16'h70CC);
    run_req(3'd3, 6'd0, 3'd1, 20'h33333, 16'h0006, 16'h5000, 0);
    run_req(3'd4, 6'd0, 3'd1, 20'h44444, 16'h0004, 16'h5000, 0);
    run_req(3'd5, 6'd0, 3'd1, 20'h66666, 16'hA000, 16'h5000, 1);
    load_flag(16'hFFFF);
    run_req(3'd0, 6'd0, 3'd0, 20'h77777, 16'hA000, 16'h5000, 1);

    for (int i = 0; i < 60; i++) begin
      if (i % 4 == 0) load_flag(16'($urandom));
      run_req(3'($urandom), 6'($urandom), 3'($urandom), 20'($urandom),
              16'($urandom), 16'($urandom), bit'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule